// File: doc/BRIEF.md
# Reset and Boot Configuration Sequencer

This block controls how a switch-style device comes out of its fundamental reset. The reset input is active-low. On the first clock edge after it is released, the block captures a set of strap pins once. From those straps it builds two 7-bit SMBus addresses: the slave address that the device answers to, and the address of the serial configuration EEPROM that the master side reads from. It also records the operating mode, the master-bus speed strap and the halt strap.

After the straps are captured, the sequencer moves through a fixed order of phases:
1. An optional serial-EEPROM load. A separate protocol engine performs the load. This block handshakes with it through a request and a done signal.
2. An optional halted hold. During the hold, both SMBus interfaces are active and the core stays stopped. An external agent ends the hold by clearing a halt bit through a register-write port.
3. Run. The core-enable output is asserted only in this phase.

Driving the reset low at any time returns the block to its idle state at once. The clock is not needed for this.

Top module: `boot_seq_top`

## Requirements
- R1: While `rstN` is low, `coreEnable`, `loadReq` and `smbActive` are 0, and `slvAddr`, `mstAddr`, `modeErr` and `slowMode` are 0. Driving `rstN` low clears `coreEnable` without waiting for a clock edge.
- R2: The slave address is `slvAddr[6:0] = {1, 1, slvStrap[3], 0, slvStrap[2], slvStrap[1], slvStrap[0]}`. Index 0 of `slvAddr` is address bit 1.
- R3: The EEPROM address is `mstAddr[6:0] = {1, 0, 1, mstStrap[3:0]}`. Index 0 of `mstAddr` is address bit 1.
- R4: The straps are captured on the first rising edge after `rstN` goes high, and `smbActive` rises on that same edge. Later changes on any strap pin have no effect on the outputs until the next reset.
- R5: Mode strap value 1 selects the EEPROM load. `loadReq` rises on the second edge after reset release. It stays high until an edge at which `loadDone` is sampled high, and falls on that edge. `loadDone` has no effect outside the load phase. Mode 0 never raises `loadReq`.
- R6: Mode strap values 2 to 7 behave like mode 0. They also set `modeErr`, which stays set until the next reset.
- R7: With the halt strap high, the block holds with `smbActive` 1 and `coreEnable` 0 once the load (if any) has finished. A halt-bit write with data 0 ends the hold, and `coreEnable` rises on the second edge after the write edge.
- R8: A halt write with data 1 keeps or sets the hold. A clearing write during the load makes the block go straight to run when the load finishes. Halt writes while running have no effect.
- R9: `slowMode` equals the captured slow-mode strap (1 = 100 kHz master clock, 0 = 400 kHz). No write input can change it.
- R10: `coreEnable` is high only in the run phase, never together with `loadReq`. Once it is high it stays high until reset.
- R11: With mode 0 or a reserved mode and no halt, `coreEnable` rises on the second edge after reset release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low fundamental reset, asynchronous |
| slvStrap | input | 4 | Slave address straps (address bits 5,3,2,1) |
| mstStrap | input | 4 | EEPROM address straps (address bits 4..1) |
| modeStrap | input | 3 | Operating mode strap |
| haltStrap | input | 1 | Halt-after-reset strap |
| slowStrap | input | 1 | Master SMBus slow-speed strap |
| haltWrEn | input | 1 | Halt-bit write strobe |
| haltWrData | input | 1 | Value written to the halt bit |
| loadDone | input | 1 | EEPROM load finished |
| slvAddr | output | 7 | Assembled slave address |
| mstAddr | output | 7 | Assembled EEPROM address |
| loadReq | output | 1 | EEPROM load request |
| smbActive | output | 1 | SMBus interfaces enabled |
| coreEnable | output | 1 | Core may start |
| modeErr | output | 1 | Sticky flag: reserved mode strapped |
| slowMode | output | 1 | Latched master-bus speed selection |

## Verification
The hardest path to reach combines the EEPROM load with the halt. It covers a halt clear that arrives while the load is still pending, and also the case where the load finishes first and the block then parks in the hold.

The stimulus reaches each case by changing the straps under reset, timing the halt write against the `loadDone` pulse, and counting edges from reset release. Strap changes after capture and halt writes while running are checked at the ports to confirm that they change nothing.

// File: rtl/boot_seq_pkg.sv
package boot_seq_pkg;
  // Encoding of the sequencer phases.
  typedef enum logic [2:0] {
    ST_RESET  = 3'd0,
    ST_SAMPLE = 3'd1,
    ST_LOAD   = 3'd2,
    ST_HALT   = 3'd3,
    ST_RUN    = 3'd4
  } bootState_e;

  // Strobes sent from the control module to the datapath.
  typedef struct packed {
    logic capture;
    logic haltClear;
    logic haltSet;
  } dpStrobe_t;

  localparam int MODE_W      = 3;
  localparam int MODE_NORMAL = 0;
  localparam int MODE_EEPROM = 1;
endpackage

// File: rtl/boot_seq_datapath.sv
module boot_seq_datapath
  import boot_seq_pkg::*;
#(
  parameter int SLV_PINS = 4,
  parameter int MST_PINS = 4,
  parameter int ADDR_W   = 7
) (
  input  logic                clk,
  input  logic                rstN,
  input  dpStrobe_t           strobe,
  input  logic [SLV_PINS-1:0] slvStrap,
  input  logic [MST_PINS-1:0] mstStrap,
  input  logic [MODE_W-1:0]   modeStrap,
  input  logic                haltStrap,
  input  logic                slowStrap,
  output logic [ADDR_W-1:0]   slvAddr,
  output logic [ADDR_W-1:0]   mstAddr,
  output logic                loadMode,
  output logic                haltBit,
  output logic                modeErr,
  output logic                slowMode
);
  localparam int SLV_LOW = 3;   // straps that drive address bits 1..3
  localparam int MST_FIX = ADDR_W - MST_PINS;
  localparam logic [MST_FIX-1:0] MST_TOP = 3'b101;

  logic [ADDR_W-1:0] slvNext;
  logic [ADDR_W-1:0] mstNext;
  logic              reservedMode;

  // Build the addresses from the straps, filling the fixed bits.
  always_comb begin
    slvNext = {2'b11, slvStrap[SLV_PINS-1], 1'b0, slvStrap[SLV_LOW-1:0]};
    mstNext = {MST_TOP, mstStrap};
    reservedMode = (modeStrap > MODE_W'(MODE_EEPROM));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      slvAddr  <= '0;
      mstAddr  <= '0;
      loadMode <= 1'b0;
      modeErr  <= 1'b0;
      slowMode <= 1'b0;
    end else if (strobe.capture) begin
      slvAddr  <= slvNext;
      mstAddr  <= mstNext;
      loadMode <= (modeStrap == MODE_W'(MODE_EEPROM));
      modeErr  <= reservedMode;
      slowMode <= slowStrap;
    end
  end

  // The halt bit is loaded from its strap at capture time; after that
  // only the write strobes from the control module change it.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      haltBit <= 1'b0;
    end else if (strobe.capture) begin
      haltBit <= haltStrap;
    end else if (strobe.haltClear) begin
      haltBit <= 1'b0;
    end else if (strobe.haltSet) begin
      haltBit <= 1'b1;
    end
  end
endmodule

// File: rtl/boot_seq_ctrl.sv
module boot_seq_ctrl
  import boot_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       loadMode,
  input  logic       haltBit,
  input  logic       loadDone,
  input  logic       haltWrEn,
  input  logic       haltWrData,
  output dpStrobe_t  strobe,
  output logic       loadReq,
  output logic       smbActive,
  output logic       coreEnable
);
  bootState_e state;
  bootState_e stateNext;
  logic       writable;

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_RESET:  stateNext = ST_SAMPLE;
      ST_SAMPLE: begin
        if (loadMode)     stateNext = ST_LOAD;
        else if (haltBit) stateNext = ST_HALT;
        else              stateNext = ST_RUN;
      end
      ST_LOAD: begin
        if (loadDone) stateNext = haltBit ? ST_HALT : ST_RUN;
      end
      ST_HALT: begin
        if (!haltBit) stateNext = ST_RUN;
      end
      ST_RUN:    stateNext = ST_RUN;
      default:   stateNext = ST_RESET;
    endcase
  end

  // Halt writes count only between capture and run.
  always_comb begin
    writable         = (state == ST_SAMPLE) || (state == ST_LOAD) || (state == ST_HALT);
    strobe.capture   = (state == ST_RESET);
    strobe.haltClear = writable && haltWrEn && !haltWrData;
    strobe.haltSet   = writable && haltWrEn && haltWrData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_RESET;
    else       state <= stateNext;
  end

  always_comb begin
    loadReq    = (state == ST_LOAD);
    smbActive  = (state != ST_RESET);
    coreEnable = (state == ST_RUN);
  end
endmodule

// File: rtl/boot_seq_top.sv
module boot_seq_top
  import boot_seq_pkg::*;
#(
  parameter int SLV_PINS = 4,
  parameter int MST_PINS = 4,
  parameter int ADDR_W   = 7
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [SLV_PINS-1:0] slvStrap,
  input  logic [MST_PINS-1:0] mstStrap,
  input  logic [2:0]          modeStrap,
  input  logic                haltStrap,
  input  logic                slowStrap,
  input  logic                haltWrEn,
  input  logic                haltWrData,
  input  logic                loadDone,
  output logic [ADDR_W-1:0]   slvAddr,
  output logic [ADDR_W-1:0]   mstAddr,
  output logic                loadReq,
  output logic                smbActive,
  output logic                coreEnable,
  output logic                modeErr,
  output logic                slowMode
);
  dpStrobe_t strobe;
  logic      loadMode;
  logic      haltBit;

  boot_seq_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .loadMode   (loadMode),
    .haltBit    (haltBit),
    .loadDone   (loadDone),
    .haltWrEn   (haltWrEn),
    .haltWrData (haltWrData),
    .strobe     (strobe),
    .loadReq    (loadReq),
    .smbActive  (smbActive),
    .coreEnable (coreEnable)
  );

  boot_seq_datapath #(
    .SLV_PINS (SLV_PINS),
    .MST_PINS (MST_PINS),
    .ADDR_W   (ADDR_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .slvStrap  (slvStrap),
    .mstStrap  (mstStrap),
    .modeStrap (modeStrap),
    .haltStrap (haltStrap),
    .slowStrap (slowStrap),
    .slvAddr   (slvAddr),
    .mstAddr   (mstAddr),
    .loadMode  (loadMode),
    .haltBit   (haltBit),
    .modeErr   (modeErr),
    .slowMode  (slowMode)
  );
endmodule

// File: rtl/boot_seq_checker.sv
module boot_seq_checker #(
  parameter int ADDR_W = 7
) (
  input logic              clk,
  input logic              rstN,
  input logic              loadDone,
  input logic [ADDR_W-1:0] slvAddr,
  input logic [ADDR_W-1:0] mstAddr,
  input logic              loadReq,
  input logic              smbActive,
  input logic              coreEnable,
  input logic              modeErr,
  input logic              slowMode
);
  a_r10_run_sticky: assert property (@(posedge clk) disable iff (!rstN)
    coreEnable |=> coreEnable);

  a_r10_run_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    coreEnable |-> (!loadReq && smbActive));

  a_r4_capture_hold: assert property (@(posedge clk) disable iff (!rstN)
    (smbActive && $past(smbActive)) |->
      ($stable(slvAddr) && $stable(mstAddr) && $stable(slowMode)));

  a_r5_load_release: assert property (@(posedge clk) disable iff (!rstN)
    (loadReq && loadDone) |=> !loadReq);

  a_r5_load_wait: assert property (@(posedge clk) disable iff (!rstN)
    (loadReq && !loadDone) |=> loadReq);

  a_r6_err_sticky: assert property (@(posedge clk) disable iff (!rstN)
    modeErr |=> modeErr);

  a_r2_slave_fixed_bits: assert property (@(posedge clk) disable iff (!rstN)
    smbActive |-> (slvAddr[6:5] == 2'b11 && !slvAddr[3]));

  a_r3_master_fixed_bits: assert property (@(posedge clk) disable iff (!rstN)
    smbActive |-> (mstAddr[6:4] == 3'b101));
endmodule

bind boot_seq_top boot_seq_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .loadDone   (loadDone),
  .slvAddr    (slvAddr),
  .mstAddr    (mstAddr),
  .loadReq    (loadReq),
  .smbActive  (smbActive),
  .coreEnable (coreEnable),
  .modeErr    (modeErr),
  .slowMode   (slowMode)
);

// File: tb/boot_seq_top_tb.sv
`timescale 1ns/1ps
module boot_seq_top_tb;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [3:0] slvStrap = '0;
  logic [3:0] mstStrap = '0;
  logic [2:0] modeStrap = '0;
  logic       haltStrap = 1'b0;
  logic       slowStrap = 1'b0;
  logic       haltWrEn = 1'b0;
  logic       haltWrData = 1'b0;
  logic       loadDone = 1'b0;
  logic [6:0] slvAddr;
  logic [6:0] mstAddr;
  logic       loadReq;
  logic       smbActive;
  logic       coreEnable;
  logic       modeErr;
  logic       slowMode;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #4 clk = ~clk;   // 8 ns period, 125 MHz

  boot_seq_top u_dut (
    .clk(clk), .rstN(rstN), .slvStrap(slvStrap), .mstStrap(mstStrap),
    .modeStrap(modeStrap), .haltStrap(haltStrap), .slowStrap(slowStrap),
    .haltWrEn(haltWrEn), .haltWrData(haltWrData), .loadDone(loadDone),
    .slvAddr(slvAddr), .mstAddr(mstAddr), .loadReq(loadReq),
    .smbActive(smbActive), .coreEnable(coreEnable), .modeErr(modeErr),
    .slowMode(slowMode)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [6:0] slvExp(input logic [3:0] s);
    return {2'b11, s[3], 1'b0, s[2:0]};
  endfunction

  function automatic logic [6:0] mstExp(input logic [3:0] m);
    return {3'b101, m};
  endfunction

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Apply straps under reset, release, and stop just after the capture edge.
  task automatic boot(input logic [3:0] s, input logic [3:0] m, input logic [2:0] md,
                      input logic h, input logic sl);
    @(negedge clk);
    rstN = 1'b0;
    slvStrap = s; mstStrap = m; modeStrap = md; haltStrap = h; slowStrap = sl;
    cyc(2);
    rstN = 1'b1;
    cyc(1);
  endtask

  task automatic t_reset;
    @(negedge clk);
    rstN = 1'b0;
    slvStrap = 4'hF; mstStrap = 4'hF; modeStrap = 3'd5; slowStrap = 1'b1;
    cyc(2);
    check("R1 coreEnable", coreEnable, 0);
    check("R1 loadReq", loadReq, 0);
    check("R1 smbActive", smbActive, 0);
    check("R1 addresses", {slvAddr, mstAddr}, 0);
    check("R1 modeErr/slowMode", {modeErr, slowMode}, 0);
  endtask

  task automatic t_normal;
    boot(4'b1010, 4'b0110, 3'd0, 1'b0, 1'b1);
    check("R4 smbActive after capture", smbActive, 1);
    check("R2 slave address", slvAddr, slvExp(4'b1010));
    check("R3 master address", mstAddr, mstExp(4'b0110));
    check("R9 slowMode", slowMode, 1);
    check("R11 coreEnable not yet", coreEnable, 0);
    slvStrap = 4'b0101; mstStrap = 4'b1001; slowStrap = 1'b0; modeStrap = 3'd1;
    cyc(1);
    check("R11 coreEnable second edge", coreEnable, 1);
    check("R5 mode0 no loadReq", loadReq, 0);
    cyc(3);
    check("R4 slave held", slvAddr, slvExp(4'b1010));
    check("R4 master held", mstAddr, mstExp(4'b0110));
    check("R9 slowMode held", slowMode, 1);
    check("R6 modeErr clear", modeErr, 0);
  endtask

  task automatic t_addrPatterns;
    boot(4'b0101, 4'b1001, 3'd0, 1'b0, 1'b0);
    check("R2 slave address alt", slvAddr, slvExp(4'b0101));
    check("R3 master address alt", mstAddr, mstExp(4'b1001));
    check("R9 slowMode low", slowMode, 0);
  endtask

  task automatic t_eeprom;
    boot(4'b0000, 4'b1111, 3'd1, 1'b0, 1'b0);
    check("R5 no loadReq at capture", loadReq, 0);
    cyc(1);
    check("R5 loadReq raised", loadReq, 1);
    check("R10 core off in load", coreEnable, 0);
    cyc(4);
    check("R5 loadReq holds", loadReq, 1);
    loadDone = 1'b1;
    cyc(1);
    loadDone = 1'b0;
    check("R5 loadReq drops", loadReq, 0);
    check("R10 run after load", coreEnable, 1);
    loadDone = 1'b1;
    cyc(2);
    loadDone = 1'b0;
    check("R5 loadDone ignored in run", {loadReq, coreEnable}, 2'b01);
  endtask

  task automatic t_halt;
    boot(4'b1111, 4'b0000, 3'd0, 1'b1, 1'b0);
    cyc(5);
    check("R7 held core off", coreEnable, 0);
    check("R7 smb active in hold", smbActive, 1);
    haltWrEn = 1'b1; haltWrData = 1'b1;
    cyc(1);
    haltWrEn = 1'b0;
    cyc(2);
    check("R8 write one keeps hold", coreEnable, 0);
    haltWrEn = 1'b1; haltWrData = 1'b0;
    cyc(1);
    haltWrEn = 1'b0;
    check("R7 one edge after clear", coreEnable, 0);
    cyc(1);
    check("R7 core enabled after clear", coreEnable, 1);
    haltWrEn = 1'b1; haltWrData = 1'b1;
    cyc(1);
    haltWrEn = 1'b0;
    cyc(2);
    check("R8 run write ignored", coreEnable, 1);
  endtask

  task automatic t_eepromHaltEarlyClear;
    boot(4'b0011, 4'b0011, 3'd1, 1'b1, 1'b0);
    cyc(1);
    check("R5 load before hold", loadReq, 1);
    haltWrEn = 1'b1; haltWrData = 1'b0;
    cyc(1);
    haltWrEn = 1'b0;
    cyc(1);
    loadDone = 1'b1;
    cyc(1);
    loadDone = 1'b0;
    check("R8 clear during load skips hold", coreEnable, 1);
  endtask

  task automatic t_eepromThenHalt;
    boot(4'b0011, 4'b0011, 3'd1, 1'b1, 1'b0);
    cyc(2);
    loadDone = 1'b1;
    cyc(1);
    loadDone = 1'b0;
    check("R7 hold after load", {loadReq, coreEnable, smbActive}, 3'b001);
    cyc(3);
    check("R7 still holding", coreEnable, 0);
    haltWrEn = 1'b1; haltWrData = 1'b0;
    cyc(1);
    haltWrEn = 1'b0;
    cyc(1);
    check("R7 run after release", coreEnable, 1);
  endtask

  task automatic t_reserved;
    boot(4'b0000, 4'b0000, 3'd5, 1'b0, 1'b0);
    check("R6 modeErr set", modeErr, 1);
    cyc(1);
    check("R6 reserved acts normal", {loadReq, coreEnable}, 2'b01);
    modeStrap = 3'd0;
    cyc(3);
    check("R6 modeErr sticky", modeErr, 1);
    boot(4'b0000, 4'b0000, 3'd7, 1'b0, 1'b0);
    check("R6 mode7 flagged", modeErr, 1);
    boot(4'b0000, 4'b0000, 3'd0, 1'b0, 1'b0);
    check("R6 cleared by reset", modeErr, 0);
  endtask

  task automatic t_asyncReset;
    boot(4'b1000, 4'b0001, 3'd0, 1'b0, 1'b1);
    cyc(2);
    check("R11 running", coreEnable, 1);
    #2;
    rstN = 1'b0;
    #1;
    check("R1 async clear coreEnable", coreEnable, 0);
    check("R1 async clear smbActive", smbActive, 0);
    cyc(1);
  endtask

  initial begin
    t_reset();
    t_normal();
    t_addrPatterns();
    t_eeprom();
    t_halt();
    t_eepromHaltEarlyClear();
    t_eepromThenHalt();
    t_reserved();
    t_asyncReset();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 20000; i++) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end
endmodule